// File: doc/BRIEF.md
# Leaf Page Permission Check and Fault Encoder

This block sits at the end of a page translation pipeline. Once the walker has found a leaf page table entry, the block is given that entry's attribute and authority bits, the kind of access being attempted, the processor's problem-state flag and the key-0 bits of the data and instruction authority mask registers. From these it works out which permissions the page grants and whether the access must be refused.

When an access is refused, the block formats the interrupt report: an interrupt kind, a cause word, and a captured fault address. An upstream stage that could not resolve the address space of the access raises a segment request. The block turns that request into a segment interrupt, and the request takes precedence over the page checks.

The block is purely combinational and holds no state.

Top module: `perm_fault_enc`

## Requirements
- R1: Access code `access_i` is 0 for read, 1 for write and 2 for execute. Code 3 is handled exactly as a read.
- R2: When `leaf_flags_i[5:4]` equals 2'b10 (guarded) and the access is execute, the access is denied with cause 0x10000000, whatever the authority bits are. In that case `grant_o` is 0. Other attribute values, or non-execute accesses, pass this check.
- R3: The authority bits in `leaf_flags_i` are: bit 3 privileged-only, bit 2 read, bit 1 read-write (grants read and write), and bit 0 execute. `grant_o` reports bit 0 read, bit 1 write and bit 2 execute.
- R4: A privileged-only page accessed with `problem_i`=1 has `grant_o`=0.
- R5: With `problem_i`=1, or on a privileged-only page with `problem_i`=0, `grant_o` equals the encoded authority, and the mask inputs have no effect.
- R6: With `problem_i`=0 on a page that is not privileged-only, the authority is reduced by the mask bits. `dmask_i[1]` (register bit 63) set removes write, `dmask_i[0]` (bit 62) set removes read, and `imask_x_i` (instruction mask bit 62) set removes execute.
- R7: If `grant_o` lacks the permission the access needs, the access is denied with protection cause 0x08000000.
- R8: A denied execute access reports kind 2 (instruction storage), with the cause on `err_code_o`, `status_o`=0 and no address capture. A denied data access reports kind 1 (data storage), with the cause on `status_o`, `err_code_o`=0, and `fault_addr_o`=`ea_i` with `fault_addr_vld_o`=1.
- R9: For a denied data write, bit 0x02000000 is ORed into `status_o`.
- R10: `seg_req_i`=1 forces a denial with `grant_o`=0, zero `status_o` and zero `err_code_o`. The kind is 4 (instruction segment) for execute, with no address capture. Otherwise the kind is 3 (data segment), with `fault_addr_o`=`ea_i` and `fault_addr_vld_o`=1.
- R11: When `deny_o`=0, the outputs `fault_kind_o`, `status_o`, `err_code_o`, `fault_addr_o` and `fault_addr_vld_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| leaf_flags_i | input | 6 | Leaf entry attribute [5:4] and authority [3:0] bits |
| access_i | input | 2 | Access type code |
| problem_i | input | 1 | Problem (user) state |
| dmask_i | input | 2 | Data authority mask key 0 (bit1 = reg bit 63, bit0 = reg bit 62) |
| imask_x_i | input | 1 | Instruction authority mask key 0 execute-deny bit |
| seg_req_i | input | 1 | Upstream address-space resolution failure |
| ea_i | input | 64 | Effective address of the access |
| grant_o | output | 3 | Granted permissions {exec, write, read} |
| deny_o | output | 1 | Access refused |
| fault_kind_o | output | 3 | 0 none, 1 data storage, 2 instr storage, 3 data segment, 4 instr segment |
| status_o | output | 32 | Data fault status word |
| err_code_o | output | 32 | Instruction fault error code |
| fault_addr_o | output | 64 | Captured fault address |
| fault_addr_vld_o | output | 1 | Fault address captured |

## Verification
Two checks can apply to the same access: the guarded-execute check and the authority check. A segment request can also arrive while a page would deny the access. The bench drives an execute on a guarded page that also lacks execute authority and expects only the guard cause on `err_code_o`. It then raises a segment request with page bits that would cause a protection denial, and expects a segment kind with zero cause words. A store through a write-masked page checks that the store bit and the protection cause merge in the same word.

// File: rtl/perm_fault_pkg.sv
package perm_fault_pkg;
  localparam int unsigned CAUSE_W = 32;
  localparam int unsigned PERM_W  = 3;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } access_e;

  typedef enum logic [2:0] {
    FK_NONE = 3'd0,
    FK_DSTO = 3'd1,
    FK_ISTO = 3'd2,
    FK_DSEG = 3'd3,
    FK_ISEG = 3'd4
  } fault_kind_e;

  localparam logic [CAUSE_W-1:0] CAUSE_GUARD = 32'h1000_0000;
  localparam logic [CAUSE_W-1:0] CAUSE_PROT  = 32'h0800_0000;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE = 32'h0200_0000;

  localparam logic [1:0] ATTR_GUARDED = 2'b10;

  // permission vector bit positions
  localparam int unsigned P_RD = 0;
  localparam int unsigned P_WR = 1;
  localparam int unsigned P_EX = 2;
endpackage

// File: rtl/perm_calc.sv
module perm_calc
  import perm_fault_pkg::*;
(
  input  logic [3:0]        auth_i,
  input  logic              problem_i,
  input  logic [1:0]        dmask_i,
  input  logic              imask_x_i,
  output logic [PERM_W-1:0] perm_o
);
  logic              priv_only;
  logic [PERM_W-1:0] encoded;
  logic [PERM_W-1:0] key_allow;

  assign priv_only = auth_i[3];

  always_comb begin
    encoded       = '0;
    encoded[P_RD] = auth_i[2] | auth_i[1];
    encoded[P_WR] = auth_i[1];
    encoded[P_EX] = auth_i[0];
  end

  always_comb begin
    key_allow       = '0;
    key_allow[P_RD] = ~dmask_i[0];
    key_allow[P_WR] = ~dmask_i[1];
    key_allow[P_EX] = ~imask_x_i;
  end

  always_comb begin
    if (priv_only && problem_i)      perm_o = '0;
    else if (problem_i || priv_only) perm_o = encoded;
    else                             perm_o = encoded & key_allow;
  end
endmodule

// File: rtl/access_check.sv
module access_check
  import perm_fault_pkg::*;
(
  input  logic [1:0]        attr_i,
  input  logic [1:0]        access_i,
  input  logic [PERM_W-1:0] perm_i,
  output logic              is_exec_o,
  output logic              is_write_o,
  output logic              guard_deny_o,
  output logic              prot_deny_o
);
  logic [PERM_W-1:0] need;

  assign is_exec_o  = (access_i == ACC_EX);
  assign is_write_o = (access_i == ACC_WR);

  always_comb begin
    need = '0;
    unique case (access_i)
      ACC_WR:  need[P_WR] = 1'b1;
      ACC_EX:  need[P_EX] = 1'b1;
      default: need[P_RD] = 1'b1; // read and reserved code
    endcase
  end

  // guarded-execute check takes precedence over authority check
  assign guard_deny_o = is_exec_o && (attr_i == ATTR_GUARDED);
  assign prot_deny_o  = !guard_deny_o && ((need & ~perm_i) != '0);
endmodule

// File: rtl/fault_fmt.sv
module fault_fmt
  import perm_fault_pkg::*;
#(
  parameter int unsigned EA_W = 64
) (
  input  logic               seg_i,
  input  logic               guard_i,
  input  logic               prot_i,
  input  logic               is_exec_i,
  input  logic               is_write_i,
  input  logic [EA_W-1:0]    ea_i,
  output logic [2:0]         kind_o,
  output logic [CAUSE_W-1:0] status_o,
  output logic [CAUSE_W-1:0] err_code_o,
  output logic [EA_W-1:0]    addr_o,
  output logic               addr_vld_o
);
  fault_kind_e        kind;
  logic [CAUSE_W-1:0] cause;

  always_comb begin
    if (guard_i)     cause = CAUSE_GUARD;
    else if (prot_i) cause = CAUSE_PROT;
    else             cause = '0;
  end

  always_comb begin
    if (seg_i)                 kind = is_exec_i ? FK_ISEG : FK_DSEG;
    else if (guard_i || prot_i) kind = is_exec_i ? FK_ISTO : FK_DSTO;
    else                       kind = FK_NONE;
  end

  always_comb begin
    status_o   = '0;
    err_code_o = '0;
    if (kind == FK_DSTO)      status_o   = cause | (is_write_i ? CAUSE_STORE : '0);
    else if (kind == FK_ISTO) err_code_o = cause;
  end

  assign addr_vld_o = (kind == FK_DSTO) || (kind == FK_DSEG);
  assign addr_o     = addr_vld_o ? ea_i : '0;
  assign kind_o     = kind;
endmodule

// File: rtl/perm_fault_enc.sv
module perm_fault_enc
  import perm_fault_pkg::*;
#(
  parameter int unsigned EA_W = 64
) (
  input  logic [5:0]         leaf_flags_i,
  input  logic [1:0]         access_i,
  input  logic               problem_i,
  input  logic [1:0]         dmask_i,
  input  logic               imask_x_i,
  input  logic               seg_req_i,
  input  logic [EA_W-1:0]    ea_i,
  output logic [PERM_W-1:0]  grant_o,
  output logic               deny_o,
  output logic [2:0]         fault_kind_o,
  output logic [CAUSE_W-1:0] status_o,
  output logic [CAUSE_W-1:0] err_code_o,
  output logic [EA_W-1:0]    fault_addr_o,
  output logic               fault_addr_vld_o
);
  logic [PERM_W-1:0] perm;
  logic is_exec, is_write, guard_deny, prot_deny;
  logic guard_eff, prot_eff;

  perm_calc u_perm_calc (
    .auth_i    (leaf_flags_i[3:0]),
    .problem_i (problem_i),
    .dmask_i   (dmask_i),
    .imask_x_i (imask_x_i),
    .perm_o    (perm)
  );

  access_check u_access_check (
    .attr_i       (leaf_flags_i[5:4]),
    .access_i     (access_i),
    .perm_i       (perm),
    .is_exec_o    (is_exec),
    .is_write_o   (is_write),
    .guard_deny_o (guard_deny),
    .prot_deny_o  (prot_deny)
  );

  // segment request overrides page checks
  assign guard_eff = guard_deny && !seg_req_i;
  assign prot_eff  = prot_deny  && !seg_req_i;

  fault_fmt #(.EA_W(EA_W)) u_fault_fmt (
    .seg_i      (seg_req_i),
    .guard_i    (guard_eff),
    .prot_i     (prot_eff),
    .is_exec_i  (is_exec),
    .is_write_i (is_write),
    .ea_i       (ea_i),
    .kind_o     (fault_kind_o),
    .status_o   (status_o),
    .err_code_o (err_code_o),
    .addr_o     (fault_addr_o),
    .addr_vld_o (fault_addr_vld_o)
  );

  assign deny_o  = seg_req_i | guard_deny | prot_deny;
  assign grant_o = (seg_req_i || guard_deny) ? '0 : perm;
endmodule

// File: rtl/perm_fault_enc_chk.sv
module perm_fault_enc_chk
  import perm_fault_pkg::*;
#(
  parameter int unsigned EA_W = 64
) (
  input logic [5:0]         leaf_flags_i,
  input logic [1:0]         access_i,
  input logic               problem_i,
  input logic               seg_req_i,
  input logic [EA_W-1:0]    ea_i,
  input logic [PERM_W-1:0]  grant_o,
  input logic               deny_o,
  input logic [2:0]         fault_kind_o,
  input logic [CAUSE_W-1:0] status_o,
  input logic [CAUSE_W-1:0] err_code_o,
  input logic [EA_W-1:0]    fault_addr_o,
  input logic               fault_addr_vld_o
);
  always_comb begin
    if (!seg_req_i && access_i == ACC_EX && leaf_flags_i[5:4] == ATTR_GUARDED)
      a_r2_guard_exec: assert (deny_o && err_code_o == CAUSE_GUARD && grant_o == '0);
    if (!seg_req_i && problem_i && leaf_flags_i[3] && leaf_flags_i[5:4] != ATTR_GUARDED)
      a_r4_priv_user: assert (grant_o == '0);
    if (!deny_o)
      a_r11_clean: assert (fault_kind_o == FK_NONE && status_o == '0 && err_code_o == '0
                           && fault_addr_o == '0 && !fault_addr_vld_o);
    if (fault_kind_o == FK_DSTO && access_i == ACC_WR)
      a_r9_store_bit: assert (status_o[25]);
    if (seg_req_i)
      a_r10_seg_zero: assert (deny_o && status_o == '0 && err_code_o == '0);
    if (fault_addr_vld_o)
      a_r8_addr_capture: assert (fault_addr_o == ea_i);
  end
endmodule

bind perm_fault_enc perm_fault_enc_chk #(.EA_W(EA_W)) u_chk (.*);

// File: tb/perm_fault_enc_bench.sv
module perm_fault_enc_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [5:0]  leaf_flags;
  logic [1:0]  access;
  logic        problem;
  logic [1:0]  dmask;
  logic        imask_x;
  logic        seg_req;
  logic [63:0] ea;
  logic [2:0]  grant;
  logic        deny;
  logic [2:0]  kind;
  logic [31:0] status;
  logic [31:0] err_code;
  logic [63:0] faddr;
  logic        faddr_vld;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  perm_fault_enc u_perm_fault_enc (
    .leaf_flags_i(leaf_flags), .access_i(access), .problem_i(problem),
    .dmask_i(dmask), .imask_x_i(imask_x), .seg_req_i(seg_req), .ea_i(ea),
    .grant_o(grant), .deny_o(deny), .fault_kind_o(kind), .status_o(status),
    .err_code_o(err_code), .fault_addr_o(faddr), .fault_addr_vld_o(faddr_vld)
  );

  task automatic drive(input logic [5:0] f, input logic [1:0] a, input logic p,
                       input logic [1:0] dm, input logic im, input logic s);
    @(negedge clk);
    leaf_flags = f; access = a; problem = p; dmask = dm; imask_x = im; seg_req = s;
    ea = 64'hC123_4567_89AB_CDE0 ^ {58'd0, f};
    #1;
  endtask

  task automatic expect_all(input string req, input logic [2:0] g, input logic d,
                            input logic [2:0] k, input logic [31:0] st,
                            input logic [31:0] ec, input logic av);
    logic [63:0] ea_exp;
    ea_exp = av ? ea : 64'd0;
    checks++;
    if (grant !== g || deny !== d || kind !== k || status !== st ||
        err_code !== ec || faddr_vld !== av || faddr !== ea_exp) begin
      errors++;
      $display("FAIL %s: got grant=%b deny=%b kind=%0d st=%h ec=%h av=%b a=%h; exp grant=%b deny=%b kind=%0d st=%h ec=%h av=%b a=%h",
               req, grant, deny, kind, status, err_code, faddr_vld, faddr,
               g, d, k, st, ec, av, ea_exp);
    end
  endtask

  task automatic t_reset_state;
    drive(6'b000100, 2'd0, 1'b1, 2'b00, 1'b0, 1'b0);
    expect_all("R11 idle read", 3'b001, 0, 0, 0, 0, 0);
  endtask

  task automatic t_basic_grants;
    drive(6'b000010, 2'd1, 1'b0, 2'b00, 1'b0, 1'b0);
    expect_all("R3 rw grants read+write", 3'b011, 0, 0, 0, 0, 0);
    drive(6'b000001, 2'd2, 1'b1, 2'b00, 1'b0, 1'b0);
    expect_all("R3 exec only", 3'b100, 0, 0, 0, 0, 0);
    drive(6'b000001, 2'd3, 1'b1, 2'b00, 1'b0, 1'b0);
    expect_all("R1 code 3 as read denied", 3'b100, 1, 1, 32'h0800_0000, 0, 1);
    drive(6'b000100, 2'd3, 1'b1, 2'b00, 1'b0, 1'b0);
    expect_all("R1 code 3 as read allowed", 3'b001, 0, 0, 0, 0, 0);
  endtask

  task automatic t_key_mask;
    drive(6'b000111, 2'd1, 1'b0, 2'b10, 1'b0, 1'b0);
    expect_all("R6 R9 mask write, store fault", 3'b101, 1, 1, 32'h0A00_0000, 0, 1);
    drive(6'b000111, 2'd0, 1'b0, 2'b01, 1'b0, 1'b0);
    expect_all("R6 R7 mask read", 3'b110, 1, 1, 32'h0800_0000, 0, 1);
    drive(6'b000111, 2'd2, 1'b0, 2'b00, 1'b1, 1'b0);
    expect_all("R6 R8 mask exec, instr storage", 3'b011, 1, 2, 0, 32'h0800_0000, 0);
  endtask

  task automatic t_mask_ignored;
    drive(6'b000111, 2'd1, 1'b1, 2'b11, 1'b1, 1'b0);
    expect_all("R5 problem state ignores mask", 3'b111, 0, 0, 0, 0, 0);
    drive(6'b001110, 2'd1, 1'b0, 2'b11, 1'b1, 1'b0);
    expect_all("R5 priv page supervisor ignores mask", 3'b011, 0, 0, 0, 0, 0);
    drive(6'b001111, 2'd1, 1'b1, 2'b00, 1'b0, 1'b0);
    expect_all("R4 priv page in problem state", 3'b000, 1, 1, 32'h0A00_0000, 0, 1);
  endtask

  task automatic t_guard;
    drive(6'b100001, 2'd2, 1'b0, 2'b00, 1'b0, 1'b0);
    expect_all("R2 guarded exec", 3'b000, 1, 2, 0, 32'h1000_0000, 0);
    drive(6'b100000, 2'd2, 1'b0, 2'b00, 1'b0, 1'b0);
    expect_all("R2 guard before prot", 3'b000, 1, 2, 0, 32'h1000_0000, 0);
    drive(6'b100100, 2'd0, 1'b0, 2'b00, 1'b0, 1'b0);
    expect_all("R2 guarded read allowed", 3'b001, 0, 0, 0, 0, 0);
    drive(6'b110001, 2'd2, 1'b0, 2'b00, 1'b0, 1'b0);
    expect_all("R2 attr 11 exec allowed", 3'b100, 0, 0, 0, 0, 0);
  endtask

  task automatic t_segment;
    drive(6'b001111, 2'd1, 1'b1, 2'b00, 1'b0, 1'b1);
    expect_all("R10 data segment over prot", 3'b000, 1, 3, 0, 0, 1);
    drive(6'b100000, 2'd2, 1'b0, 2'b00, 1'b0, 1'b1);
    expect_all("R10 instr segment over guard", 3'b000, 1, 4, 0, 0, 0);
    drive(6'b000111, 2'd0, 1'b0, 2'b00, 1'b0, 1'b1);
    expect_all("R10 segment on good page", 3'b000, 1, 3, 0, 0, 1);
  endtask

  initial begin
    leaf_flags = '0; access = '0; problem = 0; dmask = '0; imask_x = 0;
    seg_req = 0; ea = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset_state();
    t_basic_grants();
    t_key_mask();
    t_mask_ignored();
    t_guard();
    t_segment();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (10000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule